// File: doc/BRIEF.md
# Alternating-Channel Conversion Sequencer

This block decides when conversions run in a two-input delta-sigma converter model. It picks the conversion clock from one frequency-control pin. A steady high level selects an internal tick at 128000 Hz, which puts the filter null at 50 Hz. A steady low level selects an internal tick at 153600 Hz, for a 60 Hz null. Edges on the pin mean an external clock is present, and each of its rising edges then serves as one conversion tick, so the null sits at that clock's frequency divided by 2560. The internal ticks come from dividing the fast system clock. One conversion is a fixed number of ticks. The result is final as soon as that one conversion ends, with no pipeline of conversions to flush.

Consecutive conversions take turns between input 0 and input 1. When a conversion ends, the block sends a one-cycle done strobe to the serial output logic. With the strobe it gives the channel that was just converted and a stub result word, which stands in for the filter arithmetic. The block then either sleeps or opens the data-output window, depending on chip select. In the data-output window the serial logic either reports that the word has been fully shifted, or chip select rises early and aborts the transfer. Either event starts the next conversion at once.

The state machine has three states. CONVERT counts ticks. SLEEP waits for chip select. READOUT holds the data-output window. The transitions are:
- reset → CONVERT
- CONVERT → SLEEP when the last tick arrives and chip select is high
- CONVERT → READOUT when the last tick arrives and chip select is low
- SLEEP → READOUT when chip select is low
- READOUT → CONVERT when the serial logic reports the transfer complete, or when chip select rises (abort)

Top module: `pingpong_seq`

## Requirements
- R1: After reset the block is in CONVERT: conv_busy=1, dout_en=0, conv_done=0, chan_sel=0, done_chan=0, res_data=0. Conversion starts on channel 0.
- R2: A conversion ends on its CONV_TICKS-th tick. conv_done is then high for exactly one clock, one cycle after that tick.
- R3: While fo_in stays low, clk_src reads 0 (internal 60 Hz mode). A tick then occurs every SYS_HZ/153600 (integer division) system clocks.
- R4: While fo_in stays high, clk_src reads 1 (internal 50 Hz mode). A tick then occurs every SYS_HZ/128000 system clocks.
- R5: Any edge on fo_in (after a two-flop synchronizer) sets clk_src to 2 (external mode). In external mode each rising edge of fo_in is one tick. clk_src falls back to the level-selected internal mode after SYS_HZ/2560 system clocks with no edge.
- R6: Successive conversions alternate channels. At each conv_done, done_chan equals the channel just converted and chan_sel switches to the other one.
- R7: After a conversion, with cs_n high the block sleeps: conv_busy=0, dout_en=0. It stays asleep, and ticks have no effect, for as long as cs_n stays high.
- R8: A low cs_n moves SLEEP to READOUT (dout_en=1). If cs_n is already low when a conversion ends, the block goes straight to READOUT. A high xfer_end in READOUT starts a new conversion.
- R9: A rising cs_n in READOUT aborts the transfer, and conv_busy=1 from the next cycle.
- R10: cs_n activity during CONVERT has no effect on the conversion in progress.
- R11: At each conv_done, res_data is loaded with {finished channel in the MSB, count of earlier completed conversions in the lower bits}, the count starting at 0.
- R12: External clocks at both ends of the allowed range, 2.56 kHz and 307.2 kHz, complete conversions of CONV_TICKS rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fo_in | input | 1 | Frequency control: steady level or external conversion clock |
| cs_n | input | 1 | Chip select, active low: wake and abort control |
| xfer_end | input | 1 | Serial logic reports the result word fully shifted |
| conv_done | output | 1 | One-cycle strobe at the end of each conversion |
| done_chan | output | 1 | Channel of the conversion that just finished |
| chan_sel | output | 1 | Channel of the current or next conversion |
| conv_busy | output | 1 | High while in CONVERT |
| dout_en | output | 1 | High while in READOUT (data-output window) |
| clk_src | output | 2 | 0 internal 60 Hz, 1 internal 50 Hz, 2 external |
| res_data | output | RES_W | Stub conversion result |

## Verification
The bench builds the block with CONV_TICKS=3 and keeps the real SYS_HZ of 50 MHz. The internal dividers (325 and 390 cycles) and the 19531-cycle quiet window therefore have their true sizes. The short conversion brings within reach a full conversion clocked by an external source at the 2.56 kHz lower limit (about 19531 system clocks per tick), as well as one at the 307.2 kHz upper limit. A behavioural model in the bench predicts every output on every clock. The run covers mode fall-back after a single edge, sleep with ticks ignored, immediate readout, abort and channel alternation.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [1:0] {
        SRC_INT60 = 2'd0,
        SRC_INT50 = 2'd1,
        SRC_EXT   = 2'd2
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_READ  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pps_fo_detect.sv
module pps_fo_detect
    import pps_pkg::*;
#(
    parameter int QUIET_CYC = 19531
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fo_in,
    output logic     fo_rise,
    output clk_src_e src
);
    localparam int QW = $clog2(QUIET_CYC + 1);

    logic [2:0]    sync_q;
    logic [QW-1:0] quiet_q;
    logic          ext_q;
    logic          lvl, prv, any_edge;

    assign lvl      = sync_q[1];
    assign prv      = sync_q[2];
    assign any_edge = lvl ^ prv;
    assign fo_rise  = lvl & ~prv;
    assign src      = ext_q ? SRC_EXT : (lvl ? SRC_INT50 : SRC_INT60);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            quiet_q <= '0;
            ext_q   <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], fo_in};
            if (any_edge) begin
                ext_q   <= 1'b1;
                quiet_q <= '0;
            end else if (quiet_q == QW'(QUIET_CYC - 1)) begin
                ext_q   <= 1'b0;
            end else begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    // R5: an edge on the synchronized pin selects the external source
    a_r5_edge_sets_ext: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge |=> (src == SRC_EXT));
    // R5: the quiet counter never passes its window
    a_r5_quiet_bound: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= QW'(QUIET_CYC - 1));
endmodule

// File: rtl/pps_tick_gen.sv
module pps_tick_gen
    import pps_pkg::*;
#(
    parameter int DIV50 = 390,
    parameter int DIV60 = 325
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     fo_rise,
    output logic     tick
);
    localparam int DMAX = (DIV50 > DIV60) ? DIV50 : DIV60;
    localparam int DW   = $clog2(DMAX + 1);

    logic [DW-1:0] div_q;
    logic [DW-1:0] lim_m1;

    assign lim_m1 = (src == SRC_INT50) ? DW'(DIV50 - 1) : DW'(DIV60 - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (src == SRC_EXT) begin
            div_q <= '0;
            tick  <= fo_rise;
        end else if (div_q >= lim_m1) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R3/R4: divider stays below the larger division ratio
    a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q < DW'(DMAX));
    // R5: in external mode a tick needs a rising edge
    a_r5_ext_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EXT && !fo_rise) |=> !tick);
endmodule

// File: rtl/pps_conv_count.sv
module pps_conv_count #(
    parameter int N = 20480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt_q;

    assign last = en && tick && (cnt_q == CW'(N - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (last)
            cnt_q <= '0;
        else if (en && tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: tick count stays inside one conversion
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(N));
    // R2: the final tick rewinds the count
    a_r2_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt_q == '0));
endmodule

// File: rtl/pingpong_seq.sv
module pingpong_seq
    import pps_pkg::*;
#(
    parameter int SYS_HZ     = 50_000_000,
    parameter int CONV_TICKS = 20480,
    parameter int RES_W      = 24,
    parameter bit DUAL       = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fo_in,
    input  logic             cs_n,
    input  logic             xfer_end,
    output logic             conv_done,
    output logic             done_chan,
    output logic             chan_sel,
    output logic             conv_busy,
    output logic             dout_en,
    output logic [1:0]       clk_src,
    output logic [RES_W-1:0] res_data
);
    localparam int DIV50     = SYS_HZ / 128000;
    localparam int DIV60     = SYS_HZ / 153600;
    localparam int QUIET_CYC = SYS_HZ / 2560;
    localparam int SW        = RES_W - 1;

    clk_src_e   src;
    logic       fo_rise, tick, last;
    logic       cs_prev, cs_rise;
    logic       chan_q;
    logic [SW-1:0] seq_q;
    seq_state_e st_q, st_d;

    pps_fo_detect #(.QUIET_CYC(QUIET_CYC)) u_det (
        .clk(clk), .rst_n(rst_n), .fo_in(fo_in), .fo_rise(fo_rise), .src(src)
    );

    pps_tick_gen #(.DIV50(DIV50), .DIV60(DIV60)) u_tick (
        .clk(clk), .rst_n(rst_n), .src(src), .fo_rise(fo_rise), .tick(tick)
    );

    pps_conv_count #(.N(CONV_TICKS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(st_q == ST_CONV), .tick(tick), .last(last)
    );

    assign cs_rise   = cs_n && !cs_prev;
    assign clk_src   = src;
    assign conv_busy = (st_q == ST_CONV);
    assign dout_en   = (st_q == ST_READ);
    assign chan_sel  = chan_q;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CONV:  if (last) st_d = cs_n ? ST_SLEEP : ST_READ;
            ST_SLEEP: if (!cs_n) st_d = ST_READ;
            ST_READ:  if (cs_rise || xfer_end) st_d = ST_CONV;
            default:  st_d = ST_CONV;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CONV;
        else        st_q <= st_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_done <= 1'b0;
            done_chan <= 1'b0;
            res_data  <= '0;
            seq_q     <= '0;
            cs_prev   <= 1'b1;
        end else begin
            cs_prev   <= cs_n;
            conv_done <= last;
            if (last) begin
                done_chan <= chan_q;
                res_data  <= {chan_q, seq_q};
                seq_q     <= seq_q + 1'b1;
            end
        end
    end

    generate
        if (DUAL) begin : g_dual
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    chan_q <= 1'b0;
                else if (last) chan_q <= ~chan_q;
            end
            // R6: after each conversion the other channel is selected
            a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
                conv_done |-> (chan_sel != done_chan));
        end else begin : g_single
            assign chan_q = 1'b0;
        end
    endgenerate

    // R2: done strobe lasts one cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);
    // R7: sleep holds while chip select stays high
    a_r7_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && cs_n) |=> (st_q == ST_SLEEP));
    // R9: chip-select rise in readout restarts conversion
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ && cs_rise) |=> conv_busy);
    // R10: a conversion leaves CONVERT only on its last tick
    a_r10_conv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONV && !last) |=> conv_busy);
    // R11: result MSB names the finished channel
    a_r11_res_chan: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (res_data[RES_W-1] == done_chan));
    // R8: readout only follows a low chip select
    a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> !$past(cs_n));
endmodule

// File: tb/sim_pingpong_seq.sv
module sim_pingpong_seq;
    localparam int SYS_HZ = 50_000_000;
    localparam int NT     = 3;
    localparam int RW     = 24;
    localparam int D50    = SYS_HZ / 128000;
    localparam int D60    = SYS_HZ / 153600;
    localparam int QUIET  = SYS_HZ / 2560;
    localparam int WD     = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fo = 1'b0;
    logic cs_n = 1'b1;
    logic xfer_end = 1'b0;
    logic conv_done, done_chan, chan_sel, conv_busy, dout_en;
    logic [1:0] clk_src;
    logic [RW-1:0] res_data;

    always #10 clk = ~clk;

    pingpong_seq #(.SYS_HZ(SYS_HZ), .CONV_TICKS(NT), .RES_W(RW), .DUAL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .fo_in(fo), .cs_n(cs_n), .xfer_end(xfer_end),
        .conv_done(conv_done), .done_chan(done_chan), .chan_sel(chan_sel),
        .conv_busy(conv_busy), .dout_en(dout_en), .clk_src(clk_src), .res_data(res_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit fin = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // fo stimulus: steady level or toggling clock
    int fo_lvl = 0;
    int ext_hi = 0;
    int ext_lo = 0;
    int fo_cnt = 0;
    always @(negedge clk) begin
        if (ext_hi == 0) begin
            fo = fo_lvl[0];
            fo_cnt = 0;
        end else begin
            fo_cnt++;
            if (fo_cnt >= (fo ? ext_hi : ext_lo)) begin
                fo = ~fo;
                fo_cnt = 0;
            end
        end
    end

    // behavioural reference model
    int m_s1, m_s2, m_s3, m_ext, m_q, m_div, m_tick;
    int m_st, m_tc, m_chan, m_done, m_dch, m_res, m_seq, m_csp;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ext = 0; m_q = 0; m_div = 0; m_tick = 0;
            m_st = 0; m_tc = 0; m_chan = 0; m_done = 0; m_dch = 0; m_res = 0;
            m_seq = 0; m_csp = 1;
        end else begin
            int mode, lim, n_tick, n_div, n_ext, n_q, fin_conv;
            mode = m_ext ? 2 : (m_s2 ? 1 : 0);
            n_ext = m_ext; n_q = m_q;
            if (m_s2 != m_s3) begin n_ext = 1; n_q = 0; end
            else if (m_q == QUIET - 1) n_ext = 0;
            else n_q = m_q + 1;
            if (mode == 2) begin
                n_tick = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
                n_div = 0;
            end else begin
                lim = (mode == 1) ? D50 : D60;
                if (m_div >= lim - 1) begin n_tick = 1; n_div = 0; end
                else begin n_tick = 0; n_div = m_div + 1; end
            end
            fin_conv = (m_st == 0 && m_tick == 1 && m_tc == NT - 1) ? 1 : 0;
            m_done = fin_conv;
            if (fin_conv == 1) begin
                m_dch = m_chan;
                m_res = (m_chan << (RW - 1)) | m_seq;
                m_seq++;
                m_chan = 1 - m_chan;
                m_tc = 0;
                m_st = cs_n ? 1 : 2;
            end else if (m_st == 0 && m_tick == 1) m_tc++;
            else if (m_st == 1 && !cs_n) m_st = 2;
            else if (m_st == 2 && ((cs_n && m_csp == 0) || xfer_end)) m_st = 0;
            m_csp = cs_n ? 1 : 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = fo ? 1 : 0;
            m_ext = n_ext; m_q = n_q; m_div = n_div; m_tick = n_tick;
        end
    end

    // lock-step comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R2 conv_done", conv_done, m_done);
            chk("R6 done_chan", done_chan, m_dch);
            chk("R6 chan_sel", chan_sel, m_chan);
            chk("R11 res_data", int'(res_data), m_res);
            chk("R7 conv_busy", conv_busy, m_st == 0 ? 1 : 0);
            chk("R8 dout_en", dout_en, m_st == 2 ? 1 : 0);
            chk("R5 clk_src", clk_src, m_ext ? 2 : (m_s2 ? 1 : 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD && !fin) begin
            fin = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, WD);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_done(input int maxc, input string req);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (conv_done) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic kick(output int t0);
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        t0 = cyc;
    endtask

    initial begin
        int t0, el;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", conv_busy, 1);
        chk("R1 dout_en", dout_en, 0);
        chk("R1 conv_done", conv_done, 0);
        chk("R1 chan_sel", chan_sel, 0);
        chk("R1 res_data", int'(res_data), 0);
        chk("R3 clk_src low level", clk_src, 0);

        // first conversion ends asleep (R7)
        wait_done(2000, "R2 first done");
        chk("R6 first chan", done_chan, 0);
        chk("R7 asleep busy", conv_busy, 0);
        chk("R7 asleep dout", dout_en, 0);
        repeat (2500) @(negedge clk);
        chk("R7 still asleep", conv_busy, 0);
        // R8 wake, then normal transfer end
        cs_n = 1'b0;
        @(negedge clk);
        chk("R8 wake to readout", dout_en, 1);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
        chk("R8 xfer_end restarts", conv_busy, 1);
        wait_done(2000, "R2 second done");
        chk("R6 second chan", done_chan, 1);
        chk("R8 direct readout", dout_en, 1);
        // R9 abort by chip-select rise
        cs_n = 1'b1;
        @(negedge clk);
        chk("R9 abort restarts", conv_busy, 1);
        // R10 chip select toggling mid-conversion
        repeat (3) begin
            @(negedge clk); cs_n = 1'b0;
            @(negedge clk); cs_n = 1'b1;
        end
        chk("R10 still converting", conv_busy, 1);
        wait_done(2000, "R2 third done");
        chk("R11 third result", int'(res_data), 2);
        chk("R6 third chan", done_chan, 0);
        // R3 timing at 60 Hz rate
        kick(t0);
        wait_done(2000, "R3 done");
        el = cyc - t0;
        chk("R3 conversion length", (el >= (NT-1)*D60 && el <= NT*D60 + 10) ? 1 : 0, 1);

        // R4 steady high, after fall-back from the single edge (R5)
        fo_lvl = 1;
        repeat (6) @(negedge clk);
        chk("R5 edge selects external", clk_src, 2);
        repeat (QUIET + 20) @(negedge clk);
        chk("R4 clk_src high level", clk_src, 1);
        kick(t0);
        wait_done(3000, "R4 done");
        el = cyc - t0;
        chk("R4 conversion length", (el >= (NT-1)*D50 && el <= NT*D50 + 10) ? 1 : 0, 1);

        // R12 fast external clock (about 306.7 kHz)
        ext_hi = 81; ext_lo = 82;
        repeat (400) @(negedge clk);
        chk("R5 external mode", clk_src, 2);
        kick(t0);
        wait_done(2000, "R12 fast done");
        el = cyc - t0;
        chk("R12 fast length", (el >= (NT-1)*163 && el <= NT*163 + 10) ? 1 : 0, 1);
        chk("R11 fast result", int'(res_data), (1 << (RW-1)) | 5);

        // R12 slow external clock (about 2560 Hz)
        ext_hi = 9765; ext_lo = 9766;
        kick(t0);
        wait_done(80000, "R12 slow done");
        el = cyc - t0;
        chk("R12 slow length", (el >= (NT-1)*19531 && el <= NT*19531 + 10) ? 1 : 0, 1);
        chk("R12 slow clk_src", clk_src, 2);
        chk("R6 slow chan", done_chan, 0);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule